// File: doc/BRIEF.md
# Prescaled Real-Time Seconds Counter

This block keeps elapsed time from a slow clock of about 32.768 kHz. A programmable divider splits that clock into increment ticks, and each tick advances a wide elapsed-time counter. With the default prescale value the counter steps once per second. Software reads the count, sets an alarm value, and watches two status flags. One flag marks each counter step. The other marks a match with the alarm value.

The register port uses single-cycle write and read strobes and a 2-bit address. Address 0 holds the control word: the prescale value, two interrupt enables and a self-clearing restart command. Address 1 returns the counter. Address 2 holds the alarm value. Address 3 returns the status flags. A read strobe at address 3 clears the flags, but only two slow-clock cycles later. For this reason prescale values of 1 and 2 can lose events, and values of 3 or more are fully supported.

Top module: `slow_seconds_timer`

## Requirements
- R1: After reset the control word reads 0x0000_8000 (prescale 0x8000, both enables off), the counter reads 0, the alarm register reads all ones over the counter width, the status reads 0, and irq and alarmOut are low.
- R2: For a prescale value P from 1 to 65535, the counter advances exactly once every P cycles. A prescale value of 0 gives one advance every 65536 cycles.
- R3: With the reset prescale of 0x8000, the first advance after reset occurs on the 32768th clock edge, giving one step per second at 32.768 kHz.
- R4: On an advance from its all-ones value, the counter goes to 0 and keeps counting.
- R5: A control write with bit 18 set restarts the block. The counter goes to 0 and the divider reloads, so the next advance comes a full prescale period later. The stored prescale and enables stay unchanged, and bit 18 always reads 0.
- R6: Status bit 1 (step flag) is set on the same clock edge that advances the counter.
- R7: Status bit 0 (alarm flag) is set on the edge after any cycle in which the counter equals the alarm register. alarmOut follows status bit 0.
- R8: A read strobe at address 3 clears both flags on the second clock edge after the read edge, never earlier. Read strobes at other addresses, and address 3 without a read strobe, clear nothing.
- R9: If a flag's set event falls on the same edge as a pending clear, the flag stays set.
- R10: irq is high exactly when (step flag AND bit 16 step enable) OR (alarm flag AND bit 17 alarm enable).
- R11: Register map: address 0 holds the prescale in bits 15:0, the step enable in bit 16, the alarm enable in bit 17 and restart in bit 18. Address 1 is the read-only counter. Address 2 is the writable alarm value. Address 3 is the status word. rdData shows the register selected by addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe (clears status at address 3) |
| addr | input | 2 | Register select |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Selected register contents |
| irq | output | 1 | Gated interrupt request |
| alarmOut | output | 1 | Alarm flag |

## Verification
A divider that is off by one cycle, or that reloads at the wrong time, moves the counter seen at address 1 in the first period after a restart. The clock-by-clock model catches that edge at once. A wrong clear pipeline shows up on the status word within two or three cycles of a status read, as a flag that drops too early, too late, or on top of a new event. Bad interrupt gating appears on irq in the cycle the flag sets. A faulty wrap is seen on the single step past the all-ones count.

// File: rtl/rtsc_pkg.sv
package rtsc_pkg;

  typedef enum logic [1:0] {
    ADDR_MODE   = 2'd0,
    ADDR_VALUE  = 2'd1,
    ADDR_ALARM  = 2'd2,
    ADDR_STATUS = 2'd3
  } regAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic alarmWe;
  } dpStrobe_t;

endpackage

// File: rtl/rtsc_datapath.sv
module rtsc_datapath
  import rtsc_pkg::*;
#(
  parameter int PRE_W   = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_RST = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] alarmIn,
  output logic             tick,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] almVal,
  output logic             cntEqAlm
);

  localparam int DIV_W = PRE_W + 1;
  localparam logic [DIV_W-1:0] FULL_PERIOD = DIV_W'(1) << PRE_W;
  localparam logic [DIV_W-1:0] RST_RELOAD  =
    (PRE_RST == 0) ? FULL_PERIOD : DIV_W'(PRE_RST);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] reloadVal;
  logic             periodEnd;

  always_comb begin
    reloadVal = (prescale == '0) ? FULL_PERIOD : {1'b0, prescale};
    periodEnd = (divCnt == DIV_W'(1));
    tick      = periodEnd && !strobe.restart;
    cntEqAlm  = (cntVal == almVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= RST_RELOAD;
      cntVal <= '0;
    end else if (strobe.restart) begin
      divCnt <= reloadVal;
      cntVal <= '0;
    end else if (periodEnd) begin
      divCnt <= reloadVal;
      cntVal <= cntVal + CNT_W'(1);
    end else begin
      divCnt <= divCnt - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               almVal <= '1;
    else if (strobe.alarmWe) almVal <= alarmIn;
  end

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    divCnt != '0); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cntVal == '0)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !tick) |=> $stable(cntVal)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntVal == CNT_MAX) |=> (cntVal == '0)); // R4

endmodule

// File: rtl/rtsc_ctrl.sv
module rtsc_ctrl
  import rtsc_pkg::*;
#(
  parameter int PRE_W   = 16,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int PRE_RST = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  almVal,
  input  logic              cntEqAlm,
  output dpStrobe_t         strobe,
  output logic [PRE_W-1:0]  prescale,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              alarmOut
);

  localparam int INC_EN_BIT  = PRE_W;
  localparam int ALM_EN_BIT  = PRE_W + 1;
  localparam int RESTART_BIT = PRE_W + 2;
  localparam int CLR_DELAY   = 2;

  logic                 incEn, almEn;
  logic                 incFlag, almFlag;
  logic [CLR_DELAY-1:0] clrPipe;
  logic                 clrNow;
  logic                 modeWr, restartReq, statusRd;

  always_comb begin
    modeWr         = wrEn && (addr == ADDR_MODE);
    restartReq     = modeWr && wrData[RESTART_BIT];
    statusRd       = rdEn && (addr == ADDR_STATUS);
    strobe.restart = restartReq;
    strobe.alarmWe = wrEn && (addr == ADDR_ALARM);
    clrNow         = clrPipe[CLR_DELAY-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= PRE_W'(PRE_RST);
      incEn    <= 1'b0;
      almEn    <= 1'b0;
    end else if (modeWr && !wrData[RESTART_BIT]) begin
      prescale <= wrData[PRE_W-1:0];
      incEn    <= wrData[INC_EN_BIT];
      almEn    <= wrData[ALM_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrPipe <= '0;
    else       clrPipe <= {clrPipe[CLR_DELAY-2:0], statusRd};
  end

  // set events win over a pending clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incFlag <= 1'b0;
      almFlag <= 1'b0;
    end else begin
      incFlag <= tick     | (incFlag & ~clrNow);
      almFlag <= cntEqAlm | (almFlag & ~clrNow);
    end
  end

  always_comb begin
    unique case (regAddr_t'(addr))
      ADDR_MODE:   rdData = DATA_W'({almEn, incEn, prescale});
      ADDR_VALUE:  rdData = DATA_W'(cntVal);
      ADDR_ALARM:  rdData = DATA_W'(almVal);
      ADDR_STATUS: rdData = DATA_W'({incFlag, almFlag});
      default:     rdData = '0;
    endcase
    irq      = (incFlag && incEn) || (almFlag && almEn);
    alarmOut = almFlag;
  end

  AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> incFlag); // R6
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    cntEqAlm |=> almFlag); // R7
  AST_NO_EARLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (incFlag && !clrNow) |=> incFlag); // R8
  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (clrNow && !tick) |=> !incFlag); // R8
  AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> ($stable(prescale) && $stable(incEn) && $stable(almEn))); // R5

endmodule

// File: rtl/slow_seconds_timer.sv
module slow_seconds_timer
  import rtsc_pkg::*;
#(
  parameter int PRE_W   = 16,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int PRE_RST = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              alarmOut
);

  dpStrobe_t        strobe;
  logic [PRE_W-1:0] prescale;
  logic             tick;
  logic             cntEqAlm;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] almVal;

  rtsc_ctrl #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .PRE_RST(PRE_RST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .tick(tick), .cntVal(cntVal), .almVal(almVal),
    .cntEqAlm(cntEqAlm), .strobe(strobe), .prescale(prescale),
    .rdData(rdData), .irq(irq), .alarmOut(alarmOut)
  );

  rtsc_datapath #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .PRE_RST(PRE_RST)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescale(prescale),
    .alarmIn(wrData[CNT_W-1:0]), .tick(tick), .cntVal(cntVal),
    .almVal(almVal), .cntEqAlm(cntEqAlm)
  );

endmodule

// File: tb/tb_slow_seconds_timer.sv
`timescale 1ns/1ps
module tb_slow_seconds_timer;

  localparam int TB_CNT_W = 8;
  localparam int CNT_MASK = (1 << TB_CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, alarmOut;

  always #2.5 clk = ~clk;

  slow_seconds_timer #(.CNT_W(TB_CNT_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .alarmOut(alarmOut)
  );

  // behavioural reference state
  int unsigned mPre = 32768, mDiv = 32768, mCnt = 0, mAlm = CNT_MASK;
  bit mIncEn = 0, mAlmEn = 0, mInc = 0, mAlmF = 0;
  int clrQ[$];

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  function automatic int unsigned reloadOf(int unsigned p);
    return (p == 0) ? 65536 : p;
  endfunction

  task automatic modelEdge();
    bit restart, tick, clr, nInc, nAlm;
    restart = wrEn && addr == 2'd0 && wrData[18];
    tick    = (mDiv == 1) && !restart;
    clr     = 0;
    foreach (clrQ[i]) clrQ[i] = clrQ[i] - 1;
    if (clrQ.size() > 0 && clrQ[0] == 0) begin
      clr = 1;
      void'(clrQ.pop_front());
    end
    nInc = tick || (mInc && !clr);
    nAlm = (mCnt == mAlm) || (mAlmF && !clr);
    if (restart) begin
      mDiv = reloadOf(mPre);
      mCnt = 0;
    end else if (mDiv == 1) begin
      mDiv = reloadOf(mPre);
      mCnt = (mCnt + 1) & CNT_MASK;
    end else begin
      mDiv = mDiv - 1;
    end
    if (wrEn && addr == 2'd0 && !wrData[18]) begin
      mPre   = wrData[15:0];
      mIncEn = wrData[16];
      mAlmEn = wrData[17];
    end
    if (wrEn && addr == 2'd2) mAlm = wrData & CNT_MASK;
    if (rdEn && addr == 2'd3) clrQ.push_back(2);
    mInc  = nInc;
    mAlmF = nAlm;
  endtask

  task automatic compare(string tag);
    int unsigned expRd;
    bit expIrq;
    case (addr)
      2'd0: expRd = (32'(mAlmEn) << 17) | (32'(mIncEn) << 16) | mPre;
      2'd1: expRd = mCnt;
      2'd2: expRd = mAlm;
      default: expRd = (32'(mInc) << 1) | 32'(mAlmF);
    endcase
    expIrq = (mInc && mIncEn) || (mAlmF && mAlmEn);
    vectors++;
    if (rdData !== expRd) begin
      miscompares++;
      $display("FAIL %s rdData addr=%0d actual=%h expected=%h", tag, addr, rdData, expRd);
    end
    if (irq !== expIrq) begin
      miscompares++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, expIrq);
    end
    if (alarmOut !== mAlmF) begin
      miscompares++;
      $display("FAIL %s alarmOut actual=%b expected=%b", tag, alarmOut, mAlmF);
    end
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [31:0] d, string tag);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    compare(tag);
  endtask

  task automatic idle(int n, logic [1:0] a, string tag);
    for (int i = 0; i < n; i++) step(0, 0, a, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles, expected finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R11: reset values through every address
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #0.1;
      compare("R1");
    end
    // R3: default prescale, first step on edge 32768
    idle(32770, 2'd1, "R3");
    idle(3, 2'd3, "R6");
    // R8: clear lands two edges after the read
    step(0, 1, 2'd3, 0, "R8");
    idle(4, 2'd3, "R8");
    // R11: control word write and readback
    step(1, 0, 2'd0, 32'h0000_0003, "R11");
    idle(2, 2'd0, "R11");
    // R5: restart keeps prescale and enables, bit 18 reads 0
    step(1, 0, 2'd0, 32'h0007_0009, "R5");
    idle(2, 2'd0, "R5");
    idle(2, 2'd1, "R5");
    // R2: period of 3
    idle(40, 2'd1, "R2");
    idle(10, 2'd3, "R6");
    // R9: prescale 2 with frequent reads, events collide with clears
    step(1, 0, 2'd0, 32'h0000_0002, "R9");
    step(1, 0, 2'd0, 32'h0004_0000, "R9");
    for (int i = 0; i < 30; i++) step(0, (i % 3) == 0, 2'd3, 0, "R9");
    // R8: prescale 7, spaced reads, other-address reads do not clear
    step(1, 0, 2'd0, 32'h0000_0007, "R8");
    step(1, 0, 2'd0, 32'h0004_0000, "R8");
    for (int i = 0; i < 40; i++) step(0, (i % 9) == 4, 2'd3, 0, "R8");
    idle(8, 2'd3, "R8");
    step(0, 1, 2'd1, 0, "R8");
    step(0, 1, 2'd2, 0, "R8");
    idle(4, 2'd3, "R8");
    // R7: alarm match with alarm interrupt enabled
    step(1, 0, 2'd2, 32'h0000_0005, "R7");
    step(1, 0, 2'd0, 32'h0002_0004, "R7");
    step(1, 0, 2'd0, 32'h0004_0000, "R7");
    for (int i = 0; i < 60; i++) step(0, (i % 11) == 10, 2'd3, 0, "R7");
    idle(2, 2'd2, "R11");
    // R10: gating with step enable only, then both
    step(1, 0, 2'd0, 32'h0001_0004, "R10");
    for (int i = 0; i < 30; i++) step(0, (i % 7) == 0, 2'd3, 0, "R10");
    step(1, 0, 2'd0, 32'h0003_0004, "R10");
    for (int i = 0; i < 30; i++) step(0, (i % 5) == 0, 2'd3, 0, "R10");
    step(1, 0, 2'd0, 32'h0000_0004, "R10");
    idle(10, 2'd3, "R10");
    // R4: wrap past all ones at period 1
    step(1, 0, 2'd2, 32'h0000_00FA, "R4");
    step(1, 0, 2'd0, 32'h0000_0001, "R4");
    step(1, 0, 2'd0, 32'h0004_0000, "R4");
    idle(300, 2'd1, "R4");
    // R2: prescale 0 means 65536
    step(1, 0, 2'd0, 32'h0000_0000, "R2");
    step(1, 0, 2'd0, 32'h0004_0000, "R2");
    idle(65540, 2'd1, "R2");
    idle(2, 2'd0, "R2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule